// File: doc/BRIEF.md
# Reset Supervisor with Bus Watchdog

This block produces a system reset from three sources: power-up, a low supply, and a watchdog that has expired. The supply is reported by an external comparator as a supply-good level that is already synchronous to the block clock. After every reset event, the block stretches reset for a fixed number of clock cycles. The supply must stay good for that whole stretch, and any dip starts the stretch again from zero.

The watchdog needs no dedicated kick pin. It watches the two wires of an I2C bus, and every START condition on that bus restarts it. Both wires pass through a two-flop synchronizer before edge detection. A 2-bit selector picks one of three timeout lengths, and its fourth code turns the watchdog off. While reset is held, the watchdog count is kept at zero, so each new timeout is measured from the moment reset releases.

The block drives the reset in two forms, active-high and active-low, and both are registered. It also drives a one-cycle abort strobe so that a serial interface can drop any transfer in progress. All delays are parameters in clock cycles.

Top module: `rst_supervisor`

## Requirements
- R1: While `por_n` is low, `sys_rst` is 1, `sys_rst_n` is 0 and `bus_abort` is 0. After `por_n` rises, `sys_rst` stays 1 as long as `supply_ok` is 0.
- R2: `sys_rst` falls on the STRETCH-th rising clock edge of an unbroken run of edges at which `supply_ok` is sampled 1. A single edge that samples `supply_ok` as 0 restarts that run.
- R3: Any clock edge that samples `supply_ok` as 0 sets `sys_rst` to 1 on that same edge.
- R4: A START is a 1-to-0 change of `sda_i` while `scl_i` is 1, seen after two synchronizer flops. Suppose the START is applied to the pins just after edge k. The watchdog count is then cleared on edge k+3, and without further STARTs a timeout reset rises on edge k+3+timeout.
- R5: A 1-to-0 change of `sda_i` while `scl_i` is 0 does not restart the watchdog.
- R6: `wd_sel` selects the timeout: code 00 gives TMO_SHORT, 01 gives TMO_MID and 10 gives TMO_LONG cycles. Without STARTs, `sys_rst` rises on the timeout-th edge after the edge on which reset released.
- R7: With `wd_sel` = 11 the watchdog never causes a reset.
- R8: A watchdog reset holds `sys_rst` high for exactly STRETCH cycles. The watchdog count is zero when reset releases.
- R9: `bus_abort` is 1 for exactly the one cycle in which `sys_rst` has just risen, and 0 at all other times.
- R10: `sys_rst_n` is always the complement of `sys_rst`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| por_n | input | 1 | Asynchronous power-up indication, active low |
| supply_ok | input | 1 | Supply above the trip level, synchronous to `clk` |
| scl_i | input | 1 | Monitored bus clock wire |
| sda_i | input | 1 | Monitored bus data wire |
| wd_sel | input | 2 | Watchdog timeout select (11 = off) |
| sys_rst | output | 1 | System reset, active high |
| sys_rst_n | output | 1 | System reset, active low |
| bus_abort | output | 1 | One-cycle strobe when reset asserts |

## Verification
Several properties are checked on every cycle: the complement between the two reset outputs, reset asserting immediately after a low supply sample, the abort strobe matching each reset rise, and the watchdog staying silent while it is disabled. The same checks also confirm that no release happens before both a full stretch at reset level and a full run of good supply. The exact edge on which each rise and release lands can only be shown by the bench's scenarios. These scenarios cover the power-up release, the three timeout lengths, the three-cycle kick latency through the synchronizer, and SDA edges with SCL low that must be ignored. They also include a dip during the stretch, which must restart the delay.

// File: rtl/rsup_pkg.sv
package rsup_pkg;

    typedef enum logic [1:0] {
        WD_SHORT = 2'b00,
        WD_MID   = 2'b01,
        WD_LONG  = 2'b10,
        WD_OFF   = 2'b11
    } wd_sel_e;

endpackage

// File: rtl/rsup_sync.sv
module rsup_sync #(
    parameter int unsigned WIDTH  = 2,
    parameter int unsigned STAGES = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '1
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    logic [STAGES-1:0][WIDTH-1:0] stage_d, stage_q;

    always_comb begin
        stage_d[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            stage_d[i] = stage_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            stage_q <= {STAGES{RST_VAL}};
        end else begin
            stage_q <= stage_d;
        end
    end

    assign dout = stage_q[STAGES-1];

endmodule

// File: rtl/rsup_start_det.sv
module rsup_start_det (
    input  logic clk,
    input  logic por_n,
    input  logic scl_s,
    input  logic sda_s,
    output logic start
);

    typedef struct packed {
        logic scl;
        logic sda;
    } prev_t;

    prev_t prev_d, prev_q;

    always_comb begin
        prev_d.scl = scl_s;
        prev_d.sda = sda_s;
        // data falls while the clock wire is high on both samples
        start = prev_q.scl && scl_s && prev_q.sda && !sda_s;
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            prev_q <= '{scl: 1'b1, sda: 1'b1};
        end else begin
            prev_q <= prev_d;
        end
    end

endmodule

// File: rtl/rsup_wdog.sv
module rsup_wdog
    import rsup_pkg::*;
#(
    parameter int unsigned TMO_SHORT = 16,
    parameter int unsigned TMO_MID   = 32,
    parameter int unsigned TMO_LONG  = 64
) (
    input  logic    clk,
    input  logic    por_n,
    input  logic    kick,
    input  logic    hold,
    input  wd_sel_e sel,
    output logic    expire
);

    localparam int unsigned TMAX_A = (TMO_SHORT > TMO_MID) ? TMO_SHORT : TMO_MID;
    localparam int unsigned TMAX   = (TMAX_A > TMO_LONG) ? TMAX_A : TMO_LONG;
    localparam int unsigned CW     = $clog2(TMAX + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } wd_state_t;

    wd_state_t     st_d, st_q;
    logic [CW-1:0] limit;

    always_comb begin
        unique case (sel)
            WD_SHORT: limit = CW'(TMO_SHORT);
            WD_MID:   limit = CW'(TMO_MID);
            WD_LONG:  limit = CW'(TMO_LONG);
            default:  limit = '0;
        endcase
    end

    always_comb begin
        st_d   = st_q;
        expire = 1'b0;
        if (hold || (sel == WD_OFF) || kick) begin
            st_d.cnt = '0;
        end else if (st_q.cnt >= limit - 1'b1) begin
            expire   = 1'b1;
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/rsup_stretch.sv
module rsup_stretch #(
    parameter int unsigned STRETCH = 20
) (
    input  logic clk,
    input  logic por_n,
    input  logic supply_ok,
    input  logic wd_expire,
    output logic rst_d,
    output logic rst_q
);

    localparam int unsigned SW = $clog2(STRETCH + 1);

    typedef struct packed {
        logic          rst;
        logic [SW-1:0] cnt;
    } str_state_t;

    str_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!supply_ok || wd_expire) begin
            st_d.rst = 1'b1;
            st_d.cnt = '0;
        end else if (st_q.rst) begin
            if (st_q.cnt == SW'(STRETCH - 1)) begin
                st_d.rst = 1'b0;
                st_d.cnt = '0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            st_q <= '{rst: 1'b1, cnt: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign rst_d = st_d.rst;
    assign rst_q = st_q.rst;

endmodule

// File: rtl/rst_supervisor.sv
module rst_supervisor
    import rsup_pkg::*;
#(
    parameter int unsigned STRETCH     = 20,
    parameter int unsigned TMO_SHORT   = 16,
    parameter int unsigned TMO_MID     = 32,
    parameter int unsigned TMO_LONG    = 64,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       por_n,
    input  logic       supply_ok,
    input  logic       scl_i,
    input  logic       sda_i,
    input  logic [1:0] wd_sel,
    output logic       sys_rst,
    output logic       sys_rst_n,
    output logic       bus_abort
);

    typedef struct packed {
        logic rst_n;
        logic abort;
    } out_t;

    logic [1:0] bus_s;
    logic       start;
    logic       expire;
    logic       rst_d, rst_q;
    out_t       out_d, out_q;

    rsup_sync #(
        .WIDTH   (2),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (2'b11)
    ) u_sync (
        .clk   (clk),
        .por_n (por_n),
        .din   ({scl_i, sda_i}),
        .dout  (bus_s)
    );

    rsup_start_det u_start (
        .clk   (clk),
        .por_n (por_n),
        .scl_s (bus_s[1]),
        .sda_s (bus_s[0]),
        .start (start)
    );

    rsup_wdog #(
        .TMO_SHORT (TMO_SHORT),
        .TMO_MID   (TMO_MID),
        .TMO_LONG  (TMO_LONG)
    ) u_wdog (
        .clk    (clk),
        .por_n  (por_n),
        .kick   (start),
        .hold   (rst_q),
        .sel    (wd_sel_e'(wd_sel)),
        .expire (expire)
    );

    rsup_stretch #(
        .STRETCH (STRETCH)
    ) u_stretch (
        .clk       (clk),
        .por_n     (por_n),
        .supply_ok (supply_ok),
        .wd_expire (expire),
        .rst_d     (rst_d),
        .rst_q     (rst_q)
    );

    always_comb begin
        out_d.rst_n = !rst_d;
        out_d.abort = rst_d && !rst_q;
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            out_q <= '{rst_n: 1'b0, abort: 1'b0};
        end else begin
            out_q <= out_d;
        end
    end

    assign sys_rst   = rst_q;
    assign sys_rst_n = out_q.rst_n;
    assign bus_abort = out_q.abort;

endmodule

// File: rtl/rsup_checker.sv
module rsup_checker #(
    parameter int unsigned STRETCH = 20
) (
    input logic       clk,
    input logic       por_n,
    input logic       supply_ok,
    input logic [1:0] wd_sel,
    input logic       sys_rst,
    input logic       sys_rst_n,
    input logic       bus_abort
);

    localparam int unsigned SW = $clog2(STRETCH + 1);

    logic [SW-1:0] hi_run, good_run;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            hi_run   <= '0;
            good_run <= '0;
        end else begin
            hi_run   <= !sys_rst ? '0 :
                        (hi_run == SW'(STRETCH)) ? hi_run : hi_run + 1'b1;
            good_run <= !supply_ok ? '0 :
                        (good_run == SW'(STRETCH)) ? good_run : good_run + 1'b1;
        end
    end

    AST_RST_N_COMPLEMENT: assert property (@(posedge clk) disable iff (!por_n)
        sys_rst_n == !sys_rst); // R10

    AST_LOW_SUPPLY_RESET: assert property (@(posedge clk) disable iff (!por_n)
        !supply_ok |=> sys_rst); // R3

    AST_RELEASE_AFTER_STRETCH: assert property (@(posedge clk) disable iff (!por_n)
        $fell(sys_rst) |-> (hi_run == SW'(STRETCH)) && (good_run == SW'(STRETCH))); // R2

    AST_ABORT_ON_RISE: assert property (@(posedge clk) disable iff (!por_n)
        $rose(sys_rst) |-> bus_abort); // R9

    AST_ABORT_ONLY_ON_RISE: assert property (@(posedge clk) disable iff (!por_n)
        bus_abort |-> $rose(sys_rst)); // R9

    AST_WDOG_OFF_SILENT: assert property (@(posedge clk) disable iff (!por_n)
        (wd_sel == 2'b11) && supply_ok && !sys_rst |=> !sys_rst); // R7

endmodule

bind rst_supervisor rsup_checker #(
    .STRETCH (STRETCH)
) u_rsup_checker (
    .clk       (clk),
    .por_n     (por_n),
    .supply_ok (supply_ok),
    .wd_sel    (wd_sel),
    .sys_rst   (sys_rst),
    .sys_rst_n (sys_rst_n),
    .bus_abort (bus_abort)
);

// File: tb/rst_supervisor_bench.sv
module rst_supervisor_bench;

    localparam int CLK_PERIOD = 10;
    localparam int STRETCH    = 20;
    localparam int TMO_SHORT  = 16;
    localparam int TMO_MID    = 32;
    localparam int TMO_LONG   = 64;
    localparam int KICK_LAT   = 3;

    logic       clk = 1'b0;
    logic       por_n;
    logic       supply_ok;
    logic       scl_i;
    logic       sda_i;
    logic [1:0] wd_sel;
    logic       sys_rst;
    logic       sys_rst_n;
    logic       bus_abort;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;
    bit done  = 1'b0;

    typedef struct {
        bit    lvl;
        int    at;
        string req;
    } ev_t;

    ev_t exp_q[$];

    rst_supervisor #(
        .STRETCH   (STRETCH),
        .TMO_SHORT (TMO_SHORT),
        .TMO_MID   (TMO_MID),
        .TMO_LONG  (TMO_LONG)
    ) u_rst_supervisor (
        .clk       (clk),
        .por_n     (por_n),
        .supply_ok (supply_ok),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .wd_sel    (wd_sel),
        .sys_rst   (sys_rst),
        .sys_rst_n (sys_rst_n),
        .bus_abort (bus_abort)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic step(input int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic wait_until(input int t);
        while (cyc < t) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic expect_ev(input bit lvl, input int at, input string req);
        ev_t e;
        e.lvl = lvl;
        e.at  = at;
        e.req = req;
        exp_q.push_back(e);
    endtask

    task automatic kick();
        sda_i = 1'b0;
        step(2);
        sda_i = 1'b1;
    endtask

    // monitor: compares every reset transition against the queue
    initial begin : monitor
        bit prev_rst;
        prev_rst = 1'b1;
        forever begin
            @(negedge clk);
            if (por_n === 1'b1) begin
                if (sys_rst_n !== !sys_rst) begin
                    total++;
                    bad++;
                    $display("FAIL R10 sys_rst_n: actual=%0d expected=%0d", sys_rst_n, !sys_rst);
                end
                if (sys_rst && !prev_rst) begin
                    chk(bus_abort === 1'b1, "R9", "abort on rise", bus_abort, 1);
                end else if (bus_abort !== 1'b0) begin
                    total++;
                    bad++;
                    $display("FAIL R9 stray abort: actual=%0d expected=%0d", bus_abort, 0);
                end
                if (sys_rst !== prev_rst) begin
                    if (exp_q.size() == 0) begin
                        total++;
                        bad++;
                        $display("FAIL unexpected transition at cycle %0d: actual=%0d expected=%0d",
                                 cyc, sys_rst, prev_rst);
                    end else begin
                        ev_t e;
                        e = exp_q.pop_front();
                        chk(sys_rst === e.lvl, e.req, "level", sys_rst, e.lvl);
                        chk(cyc == e.at, e.req, "edge", cyc, e.at);
                    end
                    prev_rst = sys_rst;
                end
            end
        end
    end

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired: actual=%0d expected=%0d", cyc, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : driver
        int c;
        int k;
        por_n     = 1'b1;
        supply_ok = 1'b0;
        scl_i     = 1'b1;
        sda_i     = 1'b1;
        wd_sel    = 2'b00;
        #2 por_n  = 1'b0;
        step(3);
        chk(sys_rst === 1'b1, "R1", "sys_rst in por", sys_rst, 1);
        chk(sys_rst_n === 1'b0, "R1", "sys_rst_n in por", sys_rst_n, 0);
        chk(bus_abort === 1'b0, "R1", "abort in por", bus_abort, 0);
        por_n = 1'b1;
        step(4);
        chk(sys_rst === 1'b1, "R1", "held with supply low", sys_rst, 1);

        // R2 power-up release, then R6 short timeout, R8 stretch
        supply_ok = 1'b1;
        c = cyc;
        expect_ev(1'b0, c + STRETCH, "R2");
        expect_ev(1'b1, c + STRETCH + TMO_SHORT, "R6");
        expect_ev(1'b0, c + 2 * STRETCH + TMO_SHORT, "R8");
        wait_until(c + 2 * STRETCH + TMO_SHORT);

        // R4 STARTs keep the watchdog quiet; timeout counts from the last one
        k = cyc;
        for (int i = 0; i < 8; i++) begin
            k = cyc;
            kick();
            step(6);
        end
        expect_ev(1'b1, k + KICK_LAT + TMO_SHORT, "R4");
        expect_ev(1'b0, k + KICK_LAT + TMO_SHORT + STRETCH, "R8");
        wait_until(k + KICK_LAT + TMO_SHORT + STRETCH);

        // R5 SDA falls while SCL low: no restart
        c = cyc;
        expect_ev(1'b1, c + TMO_SHORT, "R5");
        expect_ev(1'b0, c + TMO_SHORT + STRETCH, "R8");
        step(3);
        scl_i = 1'b0;
        step(2);
        sda_i = 1'b0;
        step(2);
        sda_i = 1'b1;
        step(2);
        scl_i = 1'b1;
        wait_until(c + TMO_SHORT + STRETCH);

        // R6 mid timeout
        c = cyc;
        wd_sel = 2'b01;
        expect_ev(1'b1, c + TMO_MID, "R6");
        expect_ev(1'b0, c + TMO_MID + STRETCH, "R8");
        wait_until(c + TMO_MID + STRETCH);

        // R6 long timeout
        c = cyc;
        wd_sel = 2'b10;
        expect_ev(1'b1, c + TMO_LONG, "R6");
        expect_ev(1'b0, c + TMO_LONG + STRETCH, "R8");
        wait_until(c + TMO_LONG + STRETCH);

        // R7 disabled watchdog
        wd_sel = 2'b11;
        step(3 * TMO_LONG);
        chk(sys_rst === 1'b0, "R7", "no reset while off", sys_rst, 0);

        // R3 low supply, then R2 dip during stretch restarts the delay
        c = cyc;
        supply_ok = 1'b0;
        expect_ev(1'b1, c + 1, "R3");
        step(5);
        supply_ok = 1'b1;
        step(7);
        supply_ok = 1'b0;
        step(2);
        supply_ok = 1'b1;
        c = cyc;
        expect_ev(1'b0, c + STRETCH, "R2");
        wait_until(c + STRETCH + 10);

        chk(exp_q.size() == 0, "R2", "pending events", exp_q.size(), 0);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule